// File: doc/BRIEF.md
# Strobe-Handshake FIFO Buffer

A 64-word first-in first-out buffer whose two sides are driven by pulse strobes instead of enable/valid pairs. A producer raises `shift_in` while `in_ready` is high. The word on `din` is stored and `in_ready` drops to acknowledge it. A consumer watches `out_ready`. While it is high, `dout` carries the oldest unread word. The consumer takes that word with a high-then-low pulse on `shift_out`.

Both strobes are sampled by the system clock through two-flop synchronisers, and their edges are found internally. The rising edge of `shift_out` withdraws `out_ready` and leaves `dout` unchanged. The falling edge retires the word and presents the next one. Storage is a register array with independent read and write pointers. A word written into an empty buffer falls through to `dout` one clock later. When the buffer runs dry, `dout` keeps showing the last word read. The word width is a parameter: 4 by default, and 5 for the wider variant.

Top module: `strobe_fifo`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block empties itself and drives `in_ready` = 1, `out_ready` = 0 and `dout` = 0 after that edge.
- R2: Words leave through `dout` in exactly the order they were accepted, for any mix of writes and reads, up to 64 stored words.
- R3: A write happens only at a clock edge where `in_ready` is high and the synchronised `shift_in` is high following a low-to-high change. After every write, `in_ready` is low for at least the following cycle.
- R4: A `shift_in` pulse that begins and ends while `in_ready` is low changes nothing: no word is stored, and no extra word is ever delivered.
- R5: Once 64 words are held, `in_ready` stays low. It returns high at the clock edge where a word is retired. A `shift_in` that is still held high at that point is then written, and `in_ready` drops again on the next edge.
- R6: At the third clock edge after `shift_out` rises, `out_ready` goes low if it was high, and `dout` keeps its value.
- R7: At the third clock edge after `shift_out` falls, the read pointer advances. If another word is stored, it appears on `dout` with `out_ready` = 1 at that same edge. Otherwise `out_ready` stays 0.
- R8: While the buffer is empty, `out_ready` stays 0 and `dout` holds the last word read.
- R9: A word written into an empty buffer appears on `dout`, with `out_ready` = 1, exactly one clock edge after the edge that wrote it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| shift_in | input | 1 | Write strobe, asynchronous to `clk` |
| din | input | DATA_W | Word to store; must be stable while `shift_in` is high |
| in_ready | output | 1 | High when a write strobe will be accepted |
| shift_out | input | 1 | Read strobe, asynchronous to `clk` |
| out_ready | output | 1 | High when `dout` holds an unread word |
| dout | output | DATA_W | Oldest unread word, or the last word read once empty |

## Verification
Single isolated words into an empty buffer pin down the one-cycle fall-through and the hold of the last word once empty. A burst to full is followed by a drain, which exercises pointer wrap and order across all 64 slots. A strobe pulsed while full, and one held high across a read from full, separate "ignored" from "pending and then written". An interleaved write/read pattern tells apart a retire-time load of the next word from a one-cycle-later fall-through reload.

// File: rtl/strobe_fifo_pkg.sv
// Shared types for the strobe-handshake FIFO.
// Assumes: nothing beyond the standard language.
package strobe_fifo_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    // Per-cycle view of one synchronised strobe.
    typedef struct packed {
        logic level;   // synchronised strobe level
        logic rise;    // low-to-high change seen this cycle
        logic fall;    // high-to-low change seen this cycle
    } strobe_evt_t;
endpackage

// File: rtl/strobe_sync.sv
// Brings one asynchronous strobe into the clock domain and flags its edges.
// Assumes: the strobe stays at each level for longer than one clock period.
module strobe_sync
    import strobe_fifo_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        strobe_raw,
    output strobe_evt_t evt
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int TAPS = STAGES + 1;

    logic [TAPS-1:0] pipe_q;

    // Shift the raw strobe through the synchroniser plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[TAPS-2:0], strobe_raw};
    end

    // Compare the synchronised level with its previous sample.
    always_comb begin
        evt.level = pipe_q[STAGES-1];
        evt.rise  = pipe_q[STAGES-1] & ~pipe_q[STAGES];
        evt.fall  = ~pipe_q[STAGES-1] & pipe_q[STAGES];
    end
endmodule

// File: rtl/strobe_fifo_store.sv
// Dual-port register array: one synchronous write port, one combinational read port.
// Assumes: the controller never writes a slot that holds an unread word.
module strobe_fifo_store #(
    parameter int DATA_W = 4,
    parameter int DEPTH  = 64,
    parameter int AW     = 6
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [DATA_W-1:0] cells_q [DEPTH];

    // Store the incoming word in the addressed slot.
    always_ff @(posedge clk) begin
        if (wr_en) cells_q[wr_addr] <= wr_data;
    end

    // Return the addressed slot without delay.
    assign rd_data = cells_q[rd_addr];
endmodule

// File: rtl/strobe_fifo_ctrl.sv
// Pointer, occupancy and handshake control for the strobe FIFO.
// The output word is held in a register here.
// Assumes: strobe events come from strobe_sync; the array reads combinationally.
module strobe_fifo_ctrl
    import strobe_fifo_pkg::*;
#(
    parameter int DATA_W = 4,
    parameter int DEPTH  = 64,
    parameter int AW     = 6,
    parameter int CW     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  strobe_evt_t       si_evt,
    input  strobe_evt_t       so_evt,
    output logic              mem_wr_en,
    output logic [AW-1:0]     mem_wr_addr,
    output logic [AW-1:0]     mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              in_ready,
    output logic              out_ready,
    output logic [DATA_W-1:0] dout
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    logic [AW-1:0]     wr_ptr_q, rd_ptr_q, rd_ptr_nxt, wr_ptr_nxt;
    logic [CW-1:0]     count_q, count_d;
    logic              in_ready_q, out_ready_q, taking_q, si_armed_q;
    logic [DATA_W-1:0] dout_q;
    logic              wr_go, rd_go, load_next, load_fall;

    // Step a pointer forward with wrap at the array end.
    function automatic logic [AW-1:0] ptr_step(input logic [AW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + AW'(1);
    endfunction

    // Decide this cycle's write, read, load and next occupancy.
    always_comb begin
        wr_go      = si_evt.level & (si_evt.rise | si_armed_q) & in_ready_q;
        rd_go      = so_evt.fall & taking_q;
        load_next  = rd_go & (count_q > CW'(1));
        load_fall  = ~out_ready_q & ~taking_q & (count_q != '0);
        count_d    = count_q + CW'(wr_go) - CW'(rd_go);
        rd_ptr_nxt = ptr_step(rd_ptr_q);
        wr_ptr_nxt = ptr_step(wr_ptr_q);
        mem_rd_addr = rd_go ? rd_ptr_nxt : rd_ptr_q;
        mem_wr_en   = wr_go;
        mem_wr_addr = wr_ptr_q;
    end

    // Write side: pointer, pending-strobe memory and input handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q   <= '0;
            si_armed_q <= 1'b0;
            in_ready_q <= 1'b1;
        end else begin
            if (wr_go) wr_ptr_q <= wr_ptr_nxt;
            si_armed_q <= si_evt.level & (si_evt.rise | si_armed_q) & ~wr_go;
            in_ready_q <= ~wr_go & (count_d < FULL_CNT);
        end
    end

    // Occupancy count shared by both sides.
    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    // Read side: pointer, take-in-progress flag, output word and output handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr_q    <= '0;
            taking_q    <= 1'b0;
            out_ready_q <= 1'b0;
            dout_q      <= '0;
        end else begin
            if (so_evt.rise && out_ready_q) taking_q <= 1'b1;
            else if (!so_evt.level)         taking_q <= 1'b0;

            if (rd_go) rd_ptr_q <= rd_ptr_nxt;

            if (load_next || load_fall) begin
                dout_q      <= mem_rd_data;
                out_ready_q <= 1'b1;
            end else if (so_evt.rise && out_ready_q) begin
                out_ready_q <= 1'b0;
            end
        end
    end

    assign in_ready  = in_ready_q;
    assign out_ready = out_ready_q;
    assign dout      = dout_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) count_q <= FULL_CNT); // R2
    AST_WRITE_ACK: assert property (@(posedge clk) disable iff (!rst_n) wr_go |=> !in_ready_q); // R3
    AST_BUSY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !in_ready_q |=> $stable(wr_ptr_q)); // R4
    AST_FULL_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n) (count_q == FULL_CNT) |-> !in_ready_q); // R5
    AST_TAKE_HOLDS_WORD: assert property (@(posedge clk) disable iff (!rst_n) (so_evt.rise && out_ready_q) |=> (!out_ready_q && $stable(dout_q))); // R6
    AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (count_q == '0) |=> $stable(dout_q)); // R8
    AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (!rst_n) (!out_ready_q && !taking_q && count_q != '0) |=> out_ready_q); // R9
endmodule

// File: rtl/strobe_fifo.sv
// Strobe-handshake FIFO top: two strobe synchronisers, the control block and the array.
// Assumes: DEPTH >= 2; din is stable while shift_in is high.
module strobe_fifo #(
    parameter int DATA_W = 4,
    parameter int DEPTH  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_in,
    input  logic [DATA_W-1:0] din,
    output logic              in_ready,
    input  logic              shift_out,
    output logic              out_ready,
    output logic [DATA_W-1:0] dout
);
    timeunit 1ns;
    timeprecision 1ps;
    import strobe_fifo_pkg::*;

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    strobe_evt_t       si_evt, so_evt;
    logic              mem_wr_en;
    logic [AW-1:0]     mem_wr_addr, mem_rd_addr;
    logic [DATA_W-1:0] mem_rd_data;

    strobe_sync #(.STAGES(2)) u_si_sync (
        .clk(clk), .rst_n(rst_n), .strobe_raw(shift_in), .evt(si_evt)
    );

    strobe_sync #(.STAGES(2)) u_so_sync (
        .clk(clk), .rst_n(rst_n), .strobe_raw(shift_out), .evt(so_evt)
    );

    strobe_fifo_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .si_evt(si_evt), .so_evt(so_evt),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .in_ready(in_ready), .out_ready(out_ready), .dout(dout)
    );

    strobe_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_store (
        .clk(clk), .wr_en(mem_wr_en), .wr_addr(mem_wr_addr), .wr_data(din),
        .rd_addr(mem_rd_addr), .rd_data(mem_rd_data)
    );
endmodule

// File: tb/strobe_fifo_tb.sv
// Directed bench: one task per scenario, each checking its own results against a queue model.
module strobe_fifo_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int DW = 4;
    localparam int DEPTH = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic shift_in = 1'b0;
    logic shift_out = 1'b0;
    logic [DW-1:0] din = '0;
    logic in_ready, out_ready;
    logic [DW-1:0] dout;

    int n_chk = 0;
    int n_err = 0;
    logic [DW-1:0] model_q[$];

    strobe_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .shift_in(shift_in), .din(din),
        .in_ready(in_ready), .shift_out(shift_out), .out_ready(out_ready), .dout(dout)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // Write one word with a full strobe handshake.
    task automatic push(input logic [DW-1:0] w);
        int t = 0;
        while (!in_ready && t < 200) begin tick(); t++; end
        check(in_ready, "R3", "in_ready before write", int'(in_ready), 1);
        din = w;
        shift_in = 1'b1;
        t = 0;
        do begin tick(); t++; end while (in_ready && t < 20);
        check(!in_ready, "R3", "in_ready drop after write", int'(in_ready), 0);
        shift_in = 1'b0;
        model_q.push_back(w);
        repeat (3) tick();
    endtask

    // Read one word, checking hold during the take and the word shown after retire.
    task automatic pop();
        int t = 0;
        logic [DW-1:0] exp;
        while (!out_ready && t < 200) begin tick(); t++; end
        exp = (model_q.size() > 0) ? model_q[0] : '0;
        check(out_ready, "R2", "out_ready before read", int'(out_ready), 1);
        check(dout == exp, "R2", "word order", int'(dout), int'(exp));
        shift_out = 1'b1;
        t = 0;
        do begin tick(); t++; end while (out_ready && t < 20);
        check(!out_ready, "R6", "out_ready drop on take", int'(out_ready), 0);
        check(dout == exp, "R6", "word held during take", int'(dout), int'(exp));
        shift_out = 1'b0;
        repeat (3) tick();
        if (model_q.size() > 0) void'(model_q.pop_front());
        if (model_q.size() > 0) begin
            check(out_ready, "R7", "next word ready at retire", int'(out_ready), 1);
            check(dout == model_q[0], "R7", "next word at retire", int'(dout), int'(model_q[0]));
        end else begin
            check(!out_ready, "R7", "out_ready stays low when empty", int'(out_ready), 0);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
        check(out_ready == 1'b0, "R1", "out_ready after reset", int'(out_ready), 0);
        check(dout == '0, "R1", "dout after reset", int'(dout), 0);
        rst_n = 1'b1;
        repeat (2) tick();
    endtask

    task automatic t_fall_through_and_hold();
        int t = 0;
        din = 4'hA;
        shift_in = 1'b1;
        do begin tick(); t++; end while (in_ready && t < 20);
        check(!out_ready, "R9", "not ready at write edge", int'(out_ready), 0);
        tick();
        check(out_ready, "R9", "ready one edge after write", int'(out_ready), 1);
        check(dout == 4'hA, "R9", "fall-through word", int'(dout), 10);
        shift_in = 1'b0;
        model_q.push_back(4'hA);
        repeat (3) tick();
        pop();
        for (int i = 0; i < 6; i++) begin
            tick();
            check(!out_ready, "R8", "out_ready low while empty", int'(out_ready), 0);
            check(dout == 4'hA, "R8", "last word held", int'(dout), 10);
        end
    endtask

    task automatic t_order();
        for (int i = 0; i < 5; i++) push(DW'(i * 3 + 1));
        for (int i = 0; i < 5; i++) pop();
    endtask

    task automatic t_full_ignore();
        for (int i = 0; i < DEPTH; i++) push(DW'(i * 7 + 3));
        for (int i = 0; i < 8; i++) begin
            tick();
            check(!in_ready, "R5", "in_ready low while full", int'(in_ready), 0);
        end
        din = 4'hF;
        shift_in = 1'b1;
        repeat (6) tick();
        shift_in = 1'b0;
        din = 4'h0;
        repeat (4) tick();
        check(!in_ready, "R4", "still full after ignored pulse", int'(in_ready), 0);
        for (int i = 0; i < DEPTH; i++) pop();
        repeat (6) tick();
        check(!out_ready, "R4", "no extra word from ignored pulse", int'(out_ready), 0);
    endtask

    task automatic t_pending_write();
        for (int i = 0; i < DEPTH; i++) push(DW'(i * 5 + 2));
        din = 4'h9;
        shift_in = 1'b1;
        repeat (6) tick();
        check(!in_ready, "R5", "held strobe waits while full", int'(in_ready), 0);
        pop();
        check(in_ready, "R5", "in_ready back at retire edge", int'(in_ready), 1);
        tick();
        check(!in_ready, "R5", "pending strobe written", int'(in_ready), 0);
        shift_in = 1'b0;
        model_q.push_back(4'h9);
        repeat (3) tick();
        for (int i = 0; i < DEPTH; i++) pop();
        repeat (4) tick();
        check(dout == 4'h9, "R5", "pending word delivered last", int'(dout), 9);
    endtask

    task automatic t_interleave();
        push(4'h1); push(4'h2); push(4'h3);
        pop();
        push(4'h4); push(4'h5);
        pop(); pop();
        push(4'h6);
        pop(); pop(); pop();
        check(model_q.size() == 0, "R2", "model drained", model_q.size(), 0);
    endtask

    initial begin
        #1000us;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_fall_through_and_hold();
        t_order();
        t_full_ignore();
        t_pending_write();
        t_interleave();
        finish_run();
    end
endmodule